// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Core

This block is the status-reporting core of a test instrument. It keeps a standard event register that captures single-cycle event pulses and a live condition register. A per-bit transition filter turns changes of the condition register into entries of an extended event register. Each event register has its own enable mask. The block also takes the empty flags of a response (output) queue and of an error queue. From all of these it builds an 8-bit status byte whose bit 6 is a master summary of the other bits, masked by a service-request enable register.

A request-service latch sets when that master summary rises. It clears on a serial poll or when the summary falls, and it drives a service-request output. Software-side logic writes the enable masks and the filter through load strobes and reads them back on dedicated ports. It empties an event register with a read strobe, which returns the contents and clears them in the same cycle. The status byte is offered two ways: a query view with bit 6 showing the master summary, and a poll view with bit 6 showing the request latch.

Top module: `srq_status_core`

## Requirements
- R1: After reset every event register, every enable mask, the filter and the request latch are 0, so the status byte, the poll byte and `srqOut` all read 0.
- R2: Status byte bits 0, 1 and 7 always read 0. Bit 6 of the service-request enable mask is never stored: a write of 0xFF reads back as 0xBF.
- R3: Bit 2 equals the inverse of `errQEmpty` and bit 4 equals the inverse of `outQEmpty`, in the same cycle with no register in between.
- R4: Each high bit of `stdEventIn` sets the matching standard event bit at the next clock edge, and the bits accumulate. Status bit 5 is the OR of the standard event bits ANDed with the standard enable mask.
- R5: `stdEvQ` shows the standard event register. With `stdEvRd` high, the register is cleared at the next edge, except for bits set by `stdEventIn` in that same cycle, which are kept.
- R6: `condQ` follows `condIn` one edge later. Extended event bit i is set at that edge according to the 2-bit filter code at bits [2i+1:2i]: 00 never, 01 on a 0-to-1 change, 10 on a 1-to-0 change, 11 on either change.
- R7: Status bit 3 is the OR of the extended event bits ANDed with the extended enable mask. `extEvRd` reads and clears the extended event register with the same rule as R5.
- R8: Status bit 6 of the query byte is the OR, over bits 0-5 and 7, of each status bit ANDed with its service-request enable bit. A status bit whose enable bit is 0 never raises bit 6 or `srqOut`.
- R9: The request latch sets at the clock edge after the cycle in which the master summary changes from 0 to 1. `srqOut` equals the latch. `pollByte` equals the query byte with bit 6 replaced by the latch.
- R10: The latch clears at the edge after a cycle with `pollStrobe` high, or after a cycle with the master summary at 0. It does not set again until the summary falls and rises again. If a poll and a summary rise happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stdEventIn | input | STD_W | Standard event pulses, one per event source |
| condIn | input | EXT_W | Live instrument condition bits |
| outQEmpty | input | 1 | Response queue is empty |
| errQEmpty | input | 1 | Error queue is empty |
| stdEnWr | input | 1 | Load strobe for the standard enable mask |
| stdEnData | input | STD_W | New standard enable mask |
| extEnWr | input | 1 | Load strobe for the extended enable mask |
| extEnData | input | EXT_W | New extended enable mask |
| srEnWr | input | 1 | Load strobe for the service-request enable mask |
| srEnData | input | 8 | New service-request enable mask |
| filtWr | input | 1 | Load strobe for the transition filter |
| filtData | input | 2*EXT_W | New filter codes, two bits per condition bit |
| stdEvRd | input | 1 | Read-and-clear strobe for the standard event register |
| extEvRd | input | 1 | Read-and-clear strobe for the extended event register |
| pollStrobe | input | 1 | Serial poll in progress this cycle |
| stdEnQ | output | STD_W | Standard enable mask |
| extEnQ | output | EXT_W | Extended enable mask |
| srEnQ | output | 8 | Service-request enable mask |
| filtQ | output | 2*EXT_W | Transition filter codes |
| stdEvQ | output | STD_W | Standard event register contents |
| extEvQ | output | EXT_W | Extended event register contents |
| condQ | output | EXT_W | Condition register |
| statusByte | output | 8 | Query view, bit 6 is the master summary |
| pollByte | output | 8 | Poll view, bit 6 is the request latch |
| srqOut | output | 1 | Service request |

## Verification
The hardest cases to reach are those where two things happen in the same cycle. One is a read-and-clear strobe together with a fresh event that must survive the clear. The other is a serial poll together with a rise of the master summary, where the set must win. The stimulus builds each of these on purpose. A condition change is driven in the same cycle as the extended read strobe, and a standard pulse is driven together with the standard read strobe. The poll strobe is raised in exactly the cycle in which a queue flag first unmasks the summary. Latch persistence is probed by holding the summary high for several cycles after a poll and checking that the request stays cleared.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int SB_W = 8;
  localparam int EAV_BIT = 2;
  localparam int EES_BIT = 3;
  localparam int MAV_BIT = 4;
  localparam int ESB_BIT = 5;
  localparam int SUM_BIT = 6;
  localparam logic [SB_W-1:0] SR_EN_KEEP = 8'hBF;

  typedef struct packed {
    logic clrStd;
    logic clrExt;
    logic ldStdEn;
    logic ldExtEn;
    logic ldSrEn;
    logic ldFilt;
  } srqStrobes_t;
endpackage

// File: rtl/srq_transition_filter.sv
module srq_transition_filter #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [W-1:0]   condIn,
  input  logic [2*W-1:0] filt,
  output logic [W-1:0]   condQ,
  output logic [W-1:0]   hit
);
  logic [W-1:0] condReg;

  always_ff @(posedge clk) begin
    if (!rstN) condReg <= '0;
    else       condReg <= condIn;
  end

  assign condQ = condReg;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic riseEdge;
    logic fallEdge;
    assign riseEdge = condIn[i] & ~condReg[i];
    assign fallEdge = ~condIn[i] & condReg[i];
    assign hit[i] = (filt[2*i] & riseEdge) | (filt[2*i+1] & fallEdge);
  end
endmodule

// File: rtl/srq_control.sv
module srq_control
  import srq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stdEvRd,
  input  logic        extEvRd,
  input  logic        stdEnWr,
  input  logic        extEnWr,
  input  logic        srEnWr,
  input  logic        filtWr,
  input  logic        pollStrobe,
  input  logic        mss,
  output srqStrobes_t stb,
  output logic        rqs
);
  logic mssPrev;
  logic mssRise;

  always_comb begin
    stb.clrStd  = stdEvRd;
    stb.clrExt  = extEvRd;
    stb.ldStdEn = stdEnWr;
    stb.ldExtEn = extEnWr;
    stb.ldSrEn  = srEnWr;
    stb.ldFilt  = filtWr;
  end

  assign mssRise = mss & ~mssPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mssPrev <= 1'b0;
      rqs     <= 1'b0;
    end else begin
      mssPrev <= mss;
      if (mssRise)               rqs <= 1'b1;
      else if (pollStrobe || !mss) rqs <= 1'b0;
    end
  end
endmodule

// File: rtl/srq_datapath.sv
module srq_datapath
  import srq_pkg::*;
#(
  parameter int STD_W = 8,
  parameter int EXT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  srqStrobes_t        stb,
  input  logic [STD_W-1:0]   stdEventIn,
  input  logic [EXT_W-1:0]   condIn,
  input  logic               outQEmpty,
  input  logic               errQEmpty,
  input  logic [STD_W-1:0]   stdEnData,
  input  logic [EXT_W-1:0]   extEnData,
  input  logic [SB_W-1:0]    srEnData,
  input  logic [2*EXT_W-1:0] filtData,
  output logic [STD_W-1:0]   stdEnQ,
  output logic [EXT_W-1:0]   extEnQ,
  output logic [SB_W-1:0]    srEnQ,
  output logic [2*EXT_W-1:0] filtQ,
  output logic [STD_W-1:0]   stdEvQ,
  output logic [EXT_W-1:0]   extEvQ,
  output logic [EXT_W-1:0]   condQ,
  output logic [SB_W-1:0]    statusByte,
  output logic               mss
);
  logic [STD_W-1:0]   stdEv, stdEn;
  logic [EXT_W-1:0]   extEv, extEn, extHit;
  logic [SB_W-1:0]    srEn;
  logic [2*EXT_W-1:0] filtReg;
  logic [SB_W-1:0]    baseByte;

  srq_transition_filter #(.W(EXT_W)) uFilt (
    .clk   (clk),
    .rstN  (rstN),
    .condIn(condIn),
    .filt  (filtReg),
    .condQ (condQ),
    .hit   (extHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdEn   <= '0;
      extEn   <= '0;
      srEn    <= '0;
      filtReg <= '0;
    end else begin
      if (stb.ldStdEn) stdEn   <= stdEnData;
      if (stb.ldExtEn) extEn   <= extEnData;
      if (stb.ldSrEn)  srEn    <= srEnData & SR_EN_KEEP;
      if (stb.ldFilt)  filtReg <= filtData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdEv <= '0;
      extEv <= '0;
    end else begin
      stdEv <= (stb.clrStd ? '0 : stdEv) | stdEventIn;
      extEv <= (stb.clrExt ? '0 : extEv) | extHit;
    end
  end

  always_comb begin
    baseByte          = '0;
    baseByte[EAV_BIT] = ~errQEmpty;
    baseByte[EES_BIT] = |(extEv & extEn);
    baseByte[MAV_BIT] = ~outQEmpty;
    baseByte[ESB_BIT] = |(stdEv & stdEn);
  end

  assign mss = |(baseByte & srEn);

  always_comb begin
    statusByte          = baseByte;
    statusByte[SUM_BIT] = mss;
  end

  assign stdEnQ = stdEn;
  assign extEnQ = extEn;
  assign srEnQ  = srEn;
  assign filtQ  = filtReg;
  assign stdEvQ = stdEv;
  assign extEvQ = extEv;
endmodule

// File: rtl/srq_status_core.sv
module srq_status_core
  import srq_pkg::*;
#(
  parameter int STD_W = 8,
  parameter int EXT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STD_W-1:0]   stdEventIn,
  input  logic [EXT_W-1:0]   condIn,
  input  logic               outQEmpty,
  input  logic               errQEmpty,
  input  logic               stdEnWr,
  input  logic [STD_W-1:0]   stdEnData,
  input  logic               extEnWr,
  input  logic [EXT_W-1:0]   extEnData,
  input  logic               srEnWr,
  input  logic [7:0]         srEnData,
  input  logic               filtWr,
  input  logic [2*EXT_W-1:0] filtData,
  input  logic               stdEvRd,
  input  logic               extEvRd,
  input  logic               pollStrobe,
  output logic [STD_W-1:0]   stdEnQ,
  output logic [EXT_W-1:0]   extEnQ,
  output logic [7:0]         srEnQ,
  output logic [2*EXT_W-1:0] filtQ,
  output logic [STD_W-1:0]   stdEvQ,
  output logic [EXT_W-1:0]   extEvQ,
  output logic [EXT_W-1:0]   condQ,
  output logic [7:0]         statusByte,
  output logic [7:0]         pollByte,
  output logic               srqOut
);
  srqStrobes_t stb;
  logic        mss;
  logic        rqs;

  srq_control uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .stdEvRd   (stdEvRd),
    .extEvRd   (extEvRd),
    .stdEnWr   (stdEnWr),
    .extEnWr   (extEnWr),
    .srEnWr    (srEnWr),
    .filtWr    (filtWr),
    .pollStrobe(pollStrobe),
    .mss       (mss),
    .stb       (stb),
    .rqs       (rqs)
  );

  srq_datapath #(.STD_W(STD_W), .EXT_W(EXT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .stdEventIn(stdEventIn),
    .condIn    (condIn),
    .outQEmpty (outQEmpty),
    .errQEmpty (errQEmpty),
    .stdEnData (stdEnData),
    .extEnData (extEnData),
    .srEnData  (srEnData),
    .filtData  (filtData),
    .stdEnQ    (stdEnQ),
    .extEnQ    (extEnQ),
    .srEnQ     (srEnQ),
    .filtQ     (filtQ),
    .stdEvQ    (stdEvQ),
    .extEvQ    (extEvQ),
    .condQ     (condQ),
    .statusByte(statusByte),
    .mss       (mss)
  );

  always_comb begin
    pollByte          = statusByte;
    pollByte[SUM_BIT] = rqs;
  end

  assign srqOut = rqs;
endmodule

// File: rtl/srq_status_chk.sv
module srq_status_chk #(
  parameter int STD_W = 8,
  parameter int EXT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [STD_W-1:0] stdEventIn,
  input logic             errQEmpty,
  input logic             outQEmpty,
  input logic             stdEvRd,
  input logic             pollStrobe,
  input logic [STD_W-1:0] stdEvQ,
  input logic [7:0]       statusByte,
  input logic [7:0]       pollByte,
  input logic             srqOut
);
  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7] == 1'b0 && statusByte[1:0] == 2'b00);

  // R3
  queue_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[2] == !errQEmpty && statusByte[4] == !outQEmpty);

  // R5
  std_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stdEvRd && stdEventIn == '0) |=> stdEvQ == '0);

  // R9
  rqs_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] && !$past(statusByte[6])) |=> srqOut);

  // R9
  poll_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollByte[6] == srqOut && {pollByte[7], pollByte[5:0]} == {statusByte[7], statusByte[5:0]});

  // R10
  rqs_poll_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pollStrobe && !(statusByte[6] && !$past(statusByte[6]))) |=> !srqOut);

  // R10
  rqs_fall_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[6] |=> !srqOut);
endmodule

bind srq_status_core srq_status_chk #(.STD_W(STD_W), .EXT_W(EXT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .stdEventIn(stdEventIn),
  .errQEmpty (errQEmpty),
  .outQEmpty (outQEmpty),
  .stdEvRd   (stdEvRd),
  .pollStrobe(pollStrobe),
  .stdEvQ    (stdEvQ),
  .statusByte(statusByte),
  .pollByte  (pollByte),
  .srqOut    (srqOut)
);

// File: tb/srq_status_core_test.sv
`timescale 1ns/1ps
module srq_status_core_test;
  localparam int STD_W = 8;
  localparam int EXT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [STD_W-1:0] stdEventIn = '0;
  logic [EXT_W-1:0] condIn = '0;
  logic outQEmpty = 1'b1, errQEmpty = 1'b1;
  logic stdEnWr = 1'b0, extEnWr = 1'b0, srEnWr = 1'b0, filtWr = 1'b0;
  logic [STD_W-1:0] stdEnData = '0;
  logic [EXT_W-1:0] extEnData = '0;
  logic [7:0] srEnData = '0;
  logic [2*EXT_W-1:0] filtData = '0;
  logic stdEvRd = 1'b0, extEvRd = 1'b0, pollStrobe = 1'b0;
  logic [STD_W-1:0] stdEnQ, stdEvQ;
  logic [EXT_W-1:0] extEnQ, extEvQ, condQ;
  logic [7:0] srEnQ, statusByte, pollByte;
  logic [2*EXT_W-1:0] filtQ;
  logic srqOut;

  always #2 clk = ~clk;

  srq_status_core #(.STD_W(STD_W), .EXT_W(EXT_W)) uut (.*);

  typedef enum int {S_STB, S_POLL, S_SRQ, S_STDEV, S_EXTEV, S_COND,
                    S_STDEN, S_EXTEN, S_SREN, S_FILT} sel_t;
  typedef struct {
    sel_t        sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sbQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [31:0] observe(sel_t s);
    case (s)
      S_STB:   return 32'(statusByte);
      S_POLL:  return 32'(pollByte);
      S_SRQ:   return 32'(srqOut);
      S_STDEV: return 32'(stdEvQ);
      S_EXTEV: return 32'(extEvQ);
      S_COND:  return 32'(condQ);
      S_STDEN: return 32'(stdEnQ);
      S_EXTEN: return 32'(extEnQ);
      S_SREN:  return 32'(srEnQ);
      default: return 32'(filtQ);
    endcase
  endfunction

  task automatic expect_item(sel_t s, logic [31:0] e, string r);
    item_t it;
    it.sel = s; it.exp = e; it.req = r;
    sbQ.push_back(it);
  endtask

  // monitor: resolves every pending expectation mid-cycle
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbQ.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s %s: actual 0x%0h expected 0x%0h", it.req, it.sel.name(), act, it.exp);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    expect_item(S_STB, 0, "R1"); expect_item(S_POLL, 0, "R1");
    expect_item(S_SRQ, 0, "R1"); expect_item(S_STDEV, 0, "R1");
    expect_item(S_EXTEV, 0, "R1"); expect_item(S_SREN, 0, "R1");
    expect_item(S_FILT, 0, "R1");
    tick(1);

    // R3 queue flags, combinational
    errQEmpty = 1'b0; #0 expect_item(S_STB, 32'h04, "R3");
    tick(1);
    outQEmpty = 1'b0; #0 expect_item(S_STB, 32'h14, "R3");
    tick(1);
    // R2 bit 6 of the enable mask is dropped
    srEnWr = 1'b1; srEnData = 8'hFF; tick(1); srEnWr = 1'b0;
    expect_item(S_SREN, 32'hBF, "R2");
    expect_item(S_STB, 32'h54, "R8");
    expect_item(S_SRQ, 0, "R9");
    tick(1);
    expect_item(S_SRQ, 1, "R9");
    expect_item(S_POLL, 32'h54, "R9");
    pollStrobe = 1'b1; tick(1); pollStrobe = 1'b0;
    expect_item(S_SRQ, 0, "R10");
    expect_item(S_POLL, 32'h14, "R10");
    expect_item(S_STB, 32'h54, "R10");
    tick(2);
    expect_item(S_SRQ, 0, "R10");
    errQEmpty = 1'b1; outQEmpty = 1'b1; #0 expect_item(S_STB, 0, "R3");
    tick(1);
    errQEmpty = 1'b0; outQEmpty = 1'b0; tick(1);
    expect_item(S_SRQ, 1, "R9");
    errQEmpty = 1'b1; outQEmpty = 1'b1; #0 expect_item(S_SRQ, 1, "R10");
    tick(1);
    expect_item(S_SRQ, 0, "R10");

    // R8 masked bit never requests
    srEnWr = 1'b1; srEnData = 8'h20; tick(1); srEnWr = 1'b0;
    errQEmpty = 1'b0; #0 expect_item(S_STB, 32'h04, "R8");
    tick(1);
    expect_item(S_SRQ, 0, "R8");
    tick(1);
    errQEmpty = 1'b1;

    // R4 standard events
    stdEnWr = 1'b1; stdEnData = 8'h0F; tick(1); stdEnWr = 1'b0;
    expect_item(S_STDEN, 32'h0F, "R4");
    stdEventIn = 8'h30; tick(1); stdEventIn = 8'h00;
    expect_item(S_STDEV, 32'h30, "R4");
    expect_item(S_STB, 32'h00, "R4");
    stdEventIn = 8'h01; tick(1); stdEventIn = 8'h00;
    expect_item(S_STDEV, 32'h31, "R4");
    expect_item(S_STB, 32'h60, "R4");
    tick(1);
    expect_item(S_SRQ, 1, "R9");
    // R5 read-clear with concurrent event
    stdEvRd = 1'b1; stdEventIn = 8'h80; #0 expect_item(S_STDEV, 32'h31, "R5");
    tick(1); stdEvRd = 1'b0; stdEventIn = 8'h00;
    expect_item(S_STDEV, 32'h80, "R5");
    expect_item(S_STB, 32'h00, "R5");
    expect_item(S_SRQ, 1, "R10");
    tick(1);
    expect_item(S_SRQ, 0, "R10");
    stdEvRd = 1'b1; tick(1); stdEvRd = 1'b0;
    expect_item(S_STDEV, 0, "R5");

    // R6 transition filter: bit0 rise, bit1 fall, bit2 either, bit3 never
    filtWr = 1'b1; filtData = 32'h0000_0039; tick(1); filtWr = 1'b0;
    expect_item(S_FILT, 32'h39, "R6");
    extEnWr = 1'b1; extEnData = 16'h000F; tick(1); extEnWr = 1'b0;
    expect_item(S_EXTEN, 32'h000F, "R7");
    condIn = 16'h000F; tick(1);
    expect_item(S_COND, 32'h000F, "R6");
    expect_item(S_EXTEV, 32'h0005, "R6");
    expect_item(S_STB, 32'h08, "R7");
    condIn = 16'h0000; tick(1);
    expect_item(S_EXTEV, 32'h0007, "R6");
    // R7 read-clear with concurrent edge
    extEvRd = 1'b1; condIn = 16'h0004; #0 expect_item(S_EXTEV, 32'h0007, "R7");
    tick(1); extEvRd = 1'b0;
    expect_item(S_EXTEV, 32'h0004, "R7");
    expect_item(S_COND, 32'h0004, "R6");
    extEvRd = 1'b1; tick(1); extEvRd = 1'b0;
    expect_item(S_EXTEV, 0, "R7");
    expect_item(S_STB, 0, "R7");

    // R10 rise and poll in the same cycle: set wins
    srEnWr = 1'b1; srEnData = 8'h10; tick(1); srEnWr = 1'b0;
    outQEmpty = 1'b0; pollStrobe = 1'b1; tick(1); pollStrobe = 1'b0;
    expect_item(S_SRQ, 1, "R10");
    expect_item(S_POLL, 32'h50, "R9");
    tick(2);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule